// File: doc/BRIEF.md
# Glitch-Free Clock Gate with Reset and Scan Overrides

This cell stops or passes a free-running clock for a downstream group of registers. It never emits a partial or extra clock pulse. Three controls decide whether the clock runs, in fixed priority:

- An active-low reset always wins and stops the clock.
- A scan enable comes next and forces the clock to run during test.
- A functional enable only decides when neither of the other two is active.

The combined enable passes through a level-sensitive latch. The latch is open while the input clock is low and closed while it is high. The output clock is the input clock ANDed with the latched value, so a change or glitch on the enable during a high phase cannot reach the output.

A small observation flip-flop runs on the ungated clock and samples the combined enable on each rising edge. A tester can therefore read whether the enable really rose, even when the gated clock is dead because of a stuck enable.

Top module: `glitchless_cg`

## Requirements
- R1: The enable latch follows the combined enable while `clk_i` is low and holds it while `clk_i` is high. An enable change made during a high phase therefore takes effect only from the next high phase.
- R2: `gclk_o` equals `clk_i` AND the latched enable. `gclk_o` is 0 whenever `clk_i` is 0.
- R3: The combined enable is `rst_n_i & (scan_en_i | func_en_i)`. With reset released and scan off, `func_en_i` = 1 gives a pulse in the following high phase and `func_en_i` = 0 gives none.
- R4: If reset is low at a rising edge of `clk_i`, no pulse appears on `gclk_o` in that high phase, whatever the values of scan and functional enable.
- R5: With reset released, `scan_en_i` = 1 makes `gclk_o` pulse even when `func_en_i` = 0.
- R6: A pulse or dip on `func_en_i` confined to a high phase of `clk_i` does not appear on `gclk_o`.
- R7: `obs_q_o` is cleared to 0 asynchronously by reset. Otherwise it loads the combined enable on every rising edge of the ungated `clk_i`.
- R8: Every high pulse of `gclk_o` starts at a rising edge of `clk_i` and lasts a full high phase. This holds even when reset or the enables change mid-phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running input clock |
| rst_n_i | input | 1 | Active-low reset, highest priority, stops the clock |
| scan_en_i | input | 1 | Scan enable, forces the clock on when out of reset |
| func_en_i | input | 1 | Functional enable, lowest priority |
| gclk_o | output | 1 | Gated clock |
| obs_q_o | output | 1 | Combined enable sampled on the ungated clock, for test readout |

## Verification
The hardest case to reach from the ports is a control change that lands inside a high phase of the input clock. Such a change is exactly what would shorten or add a pulse in a naive gate.

The stimulus waits for a rising edge and then changes its inputs mid-phase:
- It pulses and dips the functional enable inside the high phase.
- It makes a lasting enable change inside the high phase.
- It asserts reset while an enabled pulse is in flight.

A monitor times every gated pulse against the half period throughout the run. Each scenario samples the output mid-phase in both the current and the following high phase.

// File: rtl/glitchless_cg.sv
module glitchless_cg (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic scan_en_i,
  input  logic func_en_i,
  output logic gclk_o,
  output logic obs_q_o
);

  logic en_comb;
  logic en_lat;

  assign en_comb = rst_n_i & (scan_en_i | func_en_i);

  always_latch begin
    if (!clk_i) en_lat = en_comb;
  end

  assign gclk_o = clk_i & en_lat;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) obs_q_o <= 1'b0;
    else          obs_q_o <= en_comb;
  end

  AST_GATE_MATCHES_OBS: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    gclk_o == obs_q_o); // R1

  AST_SCAN_FORCES_ON: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    scan_en_i |=> obs_q_o); // R5

  AST_FUNC_DECIDES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !scan_en_i |=> (obs_q_o == $past(func_en_i))); // R3

  AST_RESET_CLEARS_OBS: assert property (@(posedge clk_i)
    !rst_n_i |=> !obs_q_o); // R7

  AST_LOW_STAYS_LOW: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    !obs_q_o |-> !gclk_o); // R2

endmodule

// File: tb/glitchless_cg_tb_top.sv
`timescale 1ns/1ps
module glitchless_cg_tb_top;

  localparam real HALF = 2.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0;
  logic func_en = 1'b0;
  logic gclk;
  logic obs;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int bad_pulses = 0;
  realtime rise_t = 0.0;
  bit done = 1'b0;

  glitchless_cg dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .scan_en_i(scan_en), .func_en_i(func_en),
    .gclk_o(gclk), .obs_q_o(obs)
  );

  always #(HALF) clk = ~clk;

  // R8 pulse monitor
  always @(posedge gclk) begin
    rise_t = $realtime;
    if (clk !== 1'b1) bad_pulses++;
  end
  always @(negedge gclk) begin
    realtime w;
    w = $realtime - rise_t;
    pulses++;
    if (w < HALF - 0.01 || w > HALF + 0.01) begin
      bad_pulses++;
      $display("FAIL R8: pulse width %0t expected %0t", w, HALF);
    end
  end

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setup_low(input logic r, input logic s, input logic f);
    @(negedge clk); #1;
    rst_n = r; scan_en = s; func_en = f;
  endtask

  task automatic sample_high(input string tag, input logic exp_g, input logic exp_o);
    @(posedge clk); #1;
    check(gclk === exp_g, {tag, " gclk"}, gclk, exp_g);
    check(obs === exp_o, {tag, " obs"}, obs, exp_o);
  endtask

  task automatic t_reset_state();
    setup_low(1'b0, 1'b1, 1'b1);
    sample_high("R4", 1'b0, 1'b0);
    sample_high("R7", 1'b0, 1'b0);
  endtask

  task automatic t_functional();
    setup_low(1'b1, 1'b0, 1'b1);
    sample_high("R3 func on", 1'b1, 1'b1);
    #(HALF);
    check(gclk === 1'b0, "R2 low phase", gclk, 1'b0);
    setup_low(1'b1, 1'b0, 1'b0);
    sample_high("R3 func off", 1'b0, 1'b0);
    setup_low(1'b1, 1'b0, 1'b1);
    sample_high("R7 obs reload", 1'b1, 1'b1);
  endtask

  task automatic t_scan();
    setup_low(1'b1, 1'b1, 1'b0);
    sample_high("R5 scan on", 1'b1, 1'b1);
    sample_high("R5 scan held", 1'b1, 1'b1);
    setup_low(1'b0, 1'b1, 1'b0);
    sample_high("R4 reset beats scan", 1'b0, 1'b0);
  endtask

  task automatic t_glitch();
    setup_low(1'b1, 1'b0, 1'b0);
    @(posedge clk); #0.3;
    func_en = 1'b1; #0.4; func_en = 1'b0; #0.3;
    check(gclk === 1'b0, "R6 pulse blocked", gclk, 1'b0);
    check(obs === 1'b0, "R7 obs ignores glitch", obs, 1'b0);
    setup_low(1'b1, 1'b0, 1'b1);
    @(posedge clk); #0.3;
    func_en = 1'b0; #0.4; func_en = 1'b1; #0.3;
    check(gclk === 1'b1, "R6 dip blocked", gclk, 1'b1);
  endtask

  task automatic t_mid_phase_change();
    setup_low(1'b1, 1'b0, 1'b0);
    @(posedge clk); #0.5;
    func_en = 1'b1; #0.5;
    check(gclk === 1'b0, "R1 held while high", gclk, 1'b0);
    sample_high("R1 next phase", 1'b1, 1'b1);
    @(negedge clk); #1;
    @(posedge clk); #0.5;
    rst_n = 1'b0; #0.5;
    check(gclk === 1'b1, "R8 reset mid-pulse", gclk, 1'b1);
    check(obs === 1'b0, "R7 async clear", obs, 1'b0);
    sample_high("R4 after reset", 1'b0, 1'b0);
    setup_low(1'b1, 1'b0, 1'b1);
    @(posedge clk); #0.5;
    func_en = 1'b0; #0.5;
    check(gclk === 1'b1, "R8 enable drop mid-pulse", gclk, 1'b1);
    sample_high("R3 dropped", 1'b0, 1'b0);
  endtask

  initial begin
    #(100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_functional();
    t_scan();
    t_glitch();
    t_mid_phase_change();
    repeat (3) @(posedge clk);
    checks++;
    if (bad_pulses != 0 || pulses == 0) begin
      errors++;
      $display("FAIL R8: bad pulses %0d expected 0 (total %0d)", bad_pulses, pulses);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule